// File: doc/BRIEF.md
# Multi-channel edge-programmed PWM generator

This block drives sixteen pulse-width-modulated outputs from one shared time base. A prescale counter divides the input clock into steps, and a step counter walks through one period of steps. Each channel holds a rise step and a fall step. Its output goes high when the step counter reaches the rise step and goes low when it reaches the fall step. A fall step below the rise step makes the high time wrap across the period boundary. Equal steps make the output toggle once per period.

Software programs the block through a byte-wide write port. The map is: 0x00 prescale, 0x01 period, 0x02 enables of channels 0-7 (bit = channel), 0x03 enables of channels 8-15 (bit = channel - 8), 0x04 sync control (bit 0), 0x20 + 2*ch rise step of channel ch, 0x21 + 2*ch fall step of channel ch. A build-time mask marks the channels that have shadow copies of their edge steps. While sync is on, those channels and the shared prescale and period settings take new values only at the start of the next period. All other writes take effect at once.

Top module: `edge_pwm_top`

## Requirements
- R1: After reset every output is low and every channel is disabled. Prescale, period, edge steps and sync control are all zero.
- R2: One period lasts (period + 1) * (prescale + 1) clock cycles, and one step lasts prescale + 1 cycles.
- R3: With rise < fall <= period, the output is high for (fall - rise) steps in each period.
- R4: With fall < rise <= period, the high time wraps across the boundary and lasts (period + 1 - rise + fall) steps.
- R5: With rise == fall <= period, the output toggles once per period: it is high for one whole period, then low for one.
- R6: A channel whose enable bit is 0 holds its output low. Channels 0-7 are enabled by bits 0-7 of address 0x02, and channels 8-15 by bits 0-7 of address 0x03.
- R7: A channel's rising edge falls rise*(prescale + 1) cycles after the rising edge of a channel that has rise step 0.
- R8: With sync control bit 0 set, a channel in the shadow mask keeps its old edge steps until the next period starts, and uses the new ones from then on.
- R9: A channel outside the shadow mask applies a new edge step from the next clock, even while sync is on.
- R10: With sync on, a period write does not change the length of the period that is running; the new length applies from the following period.
- R11: With sync off, a channel in the shadow mask also applies new edge steps from the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register byte address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 16 | Channel outputs, bit n is channel n |

## Verification
A write presented before a rising edge is in the register after that edge. An edge step is acted on at the first clock of the step it names, and the output register shows the result one cycle later. The bench therefore measures widths, periods and phase offsets as counts of negative-edge samples between output transitions, and these counts do not depend on that fixed one-cycle delay. Shadow and immediate behaviour is told apart by sampling a fixed number of cycles after a reference channel's rise. The expected level at that sample is worked out from the step timing (two cycles per step in the test setup).

// File: rtl/edge_pwm_pkg.sv
package edge_pwm_pkg;

    localparam int STEP_W  = 8;
    localparam int ADDR_W  = 6;
    localparam int MAX_CH  = 16;

    localparam logic [ADDR_W-1:0] A_PRESCALE = 6'h00;
    localparam logic [ADDR_W-1:0] A_PERIOD   = 6'h01;
    localparam logic [ADDR_W-1:0] A_EN_BASE  = 6'h02;
    localparam logic [ADDR_W-1:0] A_SYNC     = 6'h04;
    localparam logic [ADDR_W-1:0] A_EDGE     = 6'h20;

    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        step_t rise;
        step_t fall;
    } edge_pair_t;

    function automatic logic edge_addr_hit(logic [ADDR_W-1:0] a);
        return a[ADDR_W-1];
    endfunction

    function automatic int unsigned edge_chan(logic [ADDR_W-1:0] a);
        return int'(a[ADDR_W-2:1]);
    endfunction

    function automatic logic next_level(logic cur, step_t s, edge_pair_t e);
        logic lvl;
        if (s == e.rise && s == e.fall) lvl = ~cur;
        else if (s == e.rise)           lvl = 1'b1;
        else if (s == e.fall)           lvl = 1'b0;
        else                            lvl = cur;
        return lvl;
    endfunction

endpackage

// File: rtl/edge_pwm_timebase.sv
module edge_pwm_timebase
    import edge_pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  psc_wr,
    input  logic  per_wr,
    input  step_t wr_data,
    input  logic  sync_en,
    output step_t step_cnt,
    output logic  step_start,
    output logic  boundary
);

    step_t psc_stg_q, per_stg_q, psc_act_q, per_act_q;
    step_t psc_stg_d, per_stg_d;
    step_t pre_cnt_q, step_cnt_q;
    logic  tick, load;

    assign tick     = (pre_cnt_q >= psc_act_q);
    assign boundary = tick && (step_cnt_q >= per_act_q);
    assign load     = !sync_en || boundary;
    assign psc_stg_d = psc_wr ? wr_data : psc_stg_q;
    assign per_stg_d = per_wr ? wr_data : per_stg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_stg_q  <= '0;
            per_stg_q  <= '0;
            psc_act_q  <= '0;
            per_act_q  <= '0;
            pre_cnt_q  <= '0;
            step_cnt_q <= '0;
        end else begin
            psc_stg_q <= psc_stg_d;
            per_stg_q <= per_stg_d;
            if (load) begin
                psc_act_q <= psc_stg_d;
                per_act_q <= per_stg_d;
            end
            if (tick) begin
                pre_cnt_q  <= '0;
                step_cnt_q <= boundary ? '0 : step_cnt_q + 1'b1;
            end else begin
                pre_cnt_q  <= pre_cnt_q + 1'b1;
            end
        end
    end

    assign step_cnt   = step_cnt_q;
    assign step_start = (pre_cnt_q == '0);

    assert_pre_advance_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> pre_cnt_q == $past(pre_cnt_q) + 1'b1);

    assert_step_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(step_cnt_q));

    assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (step_cnt_q == '0) && (pre_cnt_q == '0));

    assert_period_held_R10: assert property (@(posedge clk) disable iff (rst)
        (sync_en && !boundary) |=> $stable(per_act_q) && $stable(psc_act_q));

endmodule

// File: rtl/edge_pwm_chan.sv
module edge_pwm_chan
    import edge_pwm_pkg::*;
#(
    parameter bit SHADOWED = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  rise_wr,
    input  logic  fall_wr,
    input  step_t wr_data,
    input  logic  sync_en,
    input  logic  boundary,
    input  logic  step_start,
    input  step_t step_cnt,
    input  logic  enable,
    output logic  pwm_o
);

    edge_pair_t stg_q, stg_d, act_q;
    logic       out_q, load;

    always_comb begin
        stg_d = stg_q;
        if (rise_wr) stg_d.rise = wr_data;
        if (fall_wr) stg_d.fall = wr_data;
    end

    assign load = !(SHADOWED && sync_en) || boundary;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
            act_q <= '0;
            out_q <= 1'b0;
        end else begin
            stg_q <= stg_d;
            if (load) act_q <= stg_d;
            if (!enable)         out_q <= 1'b0;
            else if (step_start) out_q <= next_level(out_q, step_cnt, act_q);
        end
    end

    assign pwm_o = out_q;

    assert_disabled_low_R6: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !pwm_o);

    assert_mid_step_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (enable && !step_start) |=> $stable(pwm_o));

    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (SHADOWED && sync_en && !boundary) |=> $stable(act_q));

    assert_direct_load_R9: assert property (@(posedge clk) disable iff (rst)
        (!SHADOWED && rise_wr) |=> act_q.rise == $past(wr_data));

endmodule

// File: rtl/edge_pwm_top.sv
module edge_pwm_top
    import edge_pwm_pkg::*;
#(
    parameter int          NUM_CH      = 16,
    parameter logic [15:0] SHADOW_MASK = 16'hAAAA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [5:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic [NUM_CH-1:0] pwm_out
);

    localparam int EN_BYTES = (NUM_CH + 7) / 8;

    logic [EN_BYTES*8-1:0] en_q;
    logic                  sync_q;
    step_t                 step_cnt;
    logic                  step_start, boundary;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 1'b0;
        else if (wr_en && wr_addr == A_SYNC) sync_q <= wr_data[0];
    end

    for (genvar b = 0; b < EN_BYTES; b++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst) en_q[b*8 +: 8] <= '0;
            else if (wr_en && wr_addr == A_EN_BASE + 6'(b)) en_q[b*8 +: 8] <= wr_data;
        end
    end

    edge_pwm_timebase u_tbase (
        .clk        (clk),
        .rst        (rst),
        .psc_wr     (wr_en && wr_addr == A_PRESCALE),
        .per_wr     (wr_en && wr_addr == A_PERIOD),
        .wr_data    (wr_data),
        .sync_en    (sync_q),
        .step_cnt   (step_cnt),
        .step_start (step_start),
        .boundary   (boundary)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = wr_en && edge_addr_hit(wr_addr) && (edge_chan(wr_addr) == c);

        edge_pwm_chan #(.SHADOWED(SHADOW_MASK[c])) u_chan (
            .clk        (clk),
            .rst        (rst),
            .rise_wr    (hit && !wr_addr[0]),
            .fall_wr    (hit && wr_addr[0]),
            .wr_data    (wr_data),
            .sync_en    (sync_q),
            .boundary   (boundary),
            .step_start (step_start),
            .step_cnt   (step_cnt),
            .enable     (en_q[c]),
            .pwm_o      (pwm_out[c])
        );
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (pwm_out == '0));

endmodule

// File: tb/edge_pwm_top_tb_top.sv
module edge_pwm_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TIMEOUT    = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] pwm_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_pwm_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negative edge; returns at the next negative edge.
    task automatic wr(logic [5:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_edges(int ch, int r, int f);
        wr(6'(32 + 2*ch), 8'(r));
        wr(6'(33 + 2*ch), 8'(f));
    endtask

    // Negative edges until a low-to-high transition of channel ch is seen.
    task automatic wait_rise(int ch, output int n);
        logic prev;
        prev = pwm_out[ch];
        n = -1;
        for (int k = 1; k <= TIMEOUT; k++) begin
            @(negedge clk);
            if (!prev && pwm_out[ch]) begin n = k; break; end
            prev = pwm_out[ch];
        end
    endtask

    // From a sample where the output has level lvl, count samples until it changes.
    task automatic run_len(int ch, logic lvl, output int n);
        n = 1;
        for (int k = 0; k < TIMEOUT; k++) begin
            @(negedge clk);
            if (pwm_out[ch] != lvl) break;
            n++;
        end
    endtask

    task automatic width_check(string req, int ch, int exp_hi, int exp_lo);
        int n, hi, lo;
        wait_rise(ch, n);
        run_len(ch, 1'b1, hi);
        run_len(ch, 1'b0, lo);
        check(req, hi, exp_hi);
        check(req, lo, exp_lo);
    endtask

    initial begin
        int n, m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs low after reset while counters run
        m = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pwm_out != 0) m++;
        end
        check("R1 outputs low after reset", m, 0);

        // prescale 1, period 7 -> 2 cycles per step, 16 cycles per period
        wr(6'h00, 8'd1);
        wr(6'h01, 8'd7);
        set_edges(0, 0, 4);
        set_edges(1, 0, 4);
        set_edges(3, 2, 5);
        set_edges(4, 6, 1);
        set_edges(5, 3, 3);
        set_edges(6, 0, 4);
        set_edges(9, 1, 7);
        wr(6'h02, 8'b0011_1011);   // ch0,1,3,4,5 on; ch2 and ch6 off
        wr(6'h03, 8'b0000_0010);   // ch9 on

        width_check("R2/R3 ch0 high 4 steps, period 16", 0, 8, 8);
        width_check("R3 ch3 high 3 steps", 3, 6, 10);
        width_check("R4 ch4 wrap high 3 steps", 4, 6, 10);
        width_check("R5 ch5 toggle", 5, 16, 16);
        width_check("R6 ch9 enabled via upper byte", 9, 12, 4);

        // R6: disabled ch6 stays low
        m = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (pwm_out[6]) m++;
        end
        check("R6 disabled ch6 low", m, 0);

        // R7: phase offsets relative to ch0 (rise 0)
        wait_rise(0, n);
        wait_rise(3, n);
        check("R7 ch3 offset 2 steps", n, 4);
        wait_rise(0, n);
        wait_rise(9, n);
        check("R7 ch9 offset 1 step", n, 2);

        // R11: sync off, shadow-masked ch1 takes new fall at once
        wait_rise(0, n);           // c0: step 0, ch1 high
        wr(6'h23, 8'd2);           // ch1 fall 2, returns at c1
        repeat (5) @(negedge clk); // c6
        check("R11 ch1 fell at new step 2", int'(pwm_out[1]), 0);

        // Sync on
        wr(6'h04, 8'd1);
        set_edges(1, 0, 4);
        set_edges(2, 0, 4);
        wr(6'h02, 8'b0011_1111);
        wait_rise(0, n);           // c0
        set_edges(1, 2, 6);        // ch1 shadowed
        set_edges(2, 2, 6);        // ch2 direct; returns at c4
        repeat (6) @(negedge clk); // c10: step 4 old fall seen, step 6 not yet
        check("R8 ch1 keeps old fall in this period", int'(pwm_out[1]), 0);
        check("R9 ch2 uses new fall at once", int'(pwm_out[2]), 1);
        wait_rise(0, n);
        wait_rise(1, n);
        check("R8 ch1 new rise 2 steps after boundary", n, 4);
        run_len(1, 1'b1, n);
        check("R8 ch1 new high 4 steps", n, 8);

        // R10: period write under sync waits for the boundary
        wr(6'h21, 8'd2);           // ch0 (direct) fall 2 keeps it below the new period
        wait_rise(0, n);           // c0
        wr(6'h01, 8'd3);           // returns at c1
        wait_rise(0, n);
        check("R10 running period keeps 16 cycles", n + 1, 16);
        wait_rise(0, n);
        check("R10 next period is 8 cycles", n, 8);

        done = 1'b1;
    end

    initial begin
        for (int k = 0; k < 20000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule